// File: doc/BRIEF.md
# Lockable Encryption Activation Register

This block is a 64-bit control register that switches on memory encryption. Software can write it successfully only once. The register checks every write against its field rules and against three capability inputs: a mask of supported policy codes, a mask of supported algorithms, and the widest key-ID allocation the platform allows.

A write that passes every rule is stored, and the register locks in the same clock edge. A write that breaks any rule stores nothing and raises a one-cycle fault pulse, which the core treats as a general-protection fault. The lock can also be set by the first system-management event that arrives while the register is still unlocked. After that, only reset reopens the register.

The stored fields drive decoded status outputs. A successful write that enables encryption also produces a one-cycle request to the key machinery, either to generate a fresh key or to restore a saved one. The write port has no back-pressure. A strobed write is always taken and resolved in the cycle it is presented, and its outcome appears on the registered outputs one cycle later. The register is not a stream, so the port carries no ready signal.

Top module: `enc_act_reg`

## Requirements
- R1: After reset, rd_data is all zero, and locked, wr_fault, enc_active, key_gen_req and key_restore_req are 0.
- R2: A legal write while unlocked stores every written bit except bit 0. From the next cycle, rd_data equals the written word with bit 0 forced to 1, whatever value was written to bit 0.
- R3: A rejected write raises wr_fault for exactly one cycle, in the cycle after the write. It changes no stored bit and does not set the lock. A legal write leaves wr_fault at 0.
- R4: A write whose key-ID count (bits 35:32) exceeds cap_kid_max is rejected.
- R5: A write with a nonzero key-ID count and enable (bit 1) equal to 0 is rejected.
- R6: The policy field (bits 7:4) accepts only code 0 (XTS-128), code 1 (XTS-128 with integrity) and code 2 (XTS-256), and only when cap_policy_mask bit n is set for code n. Codes 3 to 15 are always rejected.
- R7: In the algorithm field (bits 63:48), any set bit in 63:51 is rejected. Any set bit in 50:48 whose matching cap_alg_mask bit (bit 48 maps to mask bit 0) is 0 is also rejected.
- R8: Any nonzero bit in 30:8 or 47:36 is rejected.
- R9: While locked, every write is rejected and rd_data stays unchanged. The lock clears only on reset.
- R10: smi_evt while unlocked sets bit 0 and no other bit. A later smi_evt changes nothing.
- R11: enc_active is 1 exactly when the stored enable (bit 1) is 1 and the stored bypass (bit 31) is 0.
- R12: In the cycle after a legal write with enable set, exactly one one-cycle request is raised. key_gen_req is raised when key select (bit 2) is 0, and key_restore_req when it is 1. A legal write with enable clear raises neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| smi_evt | input | 1 | System-management event; locks the register if unlocked |
| cap_policy_mask | input | NUM_POL | Bit n set when policy code n is supported |
| cap_alg_mask | input | NUM_ALG | Bit n set when algorithm bit 48+n may be allowed |
| cap_kid_max | input | 4 | Largest key-ID count a write may request |
| rd_data | output | 64 | Current register contents, including the lock |
| wr_fault | output | 1 | One-cycle pulse after a rejected write |
| locked | output | 1 | Stored lock bit |
| enc_active | output | 1 | Encryption in force (enabled, not bypassed) |
| save_key | output | 1 | Stored save-key-for-standby flag |
| policy_sel | output | 4 | Stored policy code |
| keyid_bits | output | 4 | Stored key-ID count |
| alg_allow | output | NUM_ALG | Stored allowed-algorithm bits |
| key_gen_req | output | 1 | One-cycle request to create a new key |
| key_restore_req | output | 1 | One-cycle request to restore the saved key |

## Verification
The bench sweeps every policy code against every policy-capability mask, every key-ID count against every maximum with enable both set and clear, every algorithm bit against every algorithm-capability mask, and every reserved bit on its own. A checker that was off by one on the key-ID limit, or that ignored the capability masks, would either commit words it should reject or fault on legal ones. The bench also writes the lock bit as 0 to show that bit 0 still reads back as 1. It then tries a second write after lock, which must fault and leave the contents untouched. It raises the event before and after a write, and a design that let the event alter other bits, or the lock fall, would read back wrong. Finally it runs every combination of enable, key select and bypass, which catches a request steered to the wrong output or raised without enable.

// File: rtl/enc_act_pkg.sv
package enc_act_pkg;

  // Field widths; positions follow from the packed order below.
  localparam int REG_W = 64;
  localparam int POL_W = 4;
  localparam int KID_W = 4;
  localparam int ALG_W = 16;
  localparam int RSV_LO_W = 23;
  localparam int RSV_HI_W = 12;

  typedef enum logic [POL_W-1:0] {
    POL_XTS128     = 4'd0,
    POL_XTS128_INT = 4'd1,
    POL_XTS256     = 4'd2
  } pol_code_e;

  // Packed MSB first: alg[63:48] rsv_hi[47:36] kid[35:32] byp[31]
  // rsv_lo[30:8] pol[7:4] save[3] ksel[2] en[1] lock[0]
  typedef struct packed {
    logic [ALG_W-1:0]    alg;
    logic [RSV_HI_W-1:0] rsv_hi;
    logic [KID_W-1:0]    kid;
    logic                byp;
    logic [RSV_LO_W-1:0] rsv_lo;
    logic [POL_W-1:0]    pol;
    logic                save;
    logic                ksel;
    logic                en;
    logic                lock;
  } act_reg_t;

endpackage

// File: rtl/enc_act_validate.sv
module enc_act_validate
  import enc_act_pkg::*;
#(
  parameter int NUM_POL = 3,
  parameter int NUM_ALG = 3
) (
  input  act_reg_t           wr_word,
  input  logic               locked,
  input  logic [NUM_POL-1:0] cap_pol,
  input  logic [NUM_ALG-1:0] cap_alg,
  input  logic [KID_W-1:0]   cap_kid_max,
  output logic               legal
);

  logic [NUM_POL-1:0] pol_hit;
  logic [ALG_W-1:0]   alg_bad;
  logic               pol_ok;
  logic               kid_ok;
  logic               rsv_ok;
  logic               alg_ok;
  logic               unused_fields;

  // A policy code is accepted only if it names a known algorithm and the
  // capability mask enables that code.
  for (genvar i = 0; i < NUM_POL; i++) begin : g_pol
    assign pol_hit[i] = (wr_word.pol == POL_W'(i)) & cap_pol[i];
  end
  assign pol_ok = |pol_hit;

  // Known algorithm bits must be supported; the rest are reserved.
  for (genvar j = 0; j < ALG_W; j++) begin : g_alg
    if (j < NUM_ALG) begin : g_known
      assign alg_bad[j] = wr_word.alg[j] & ~cap_alg[j];
    end else begin : g_rsv
      assign alg_bad[j] = wr_word.alg[j];
    end
  end
  assign alg_ok = ~|alg_bad;

  assign kid_ok = (wr_word.kid <= cap_kid_max) &&
                  ((wr_word.kid == '0) || wr_word.en);
  assign rsv_ok = (wr_word.rsv_lo == '0) && (wr_word.rsv_hi == '0);

  assign legal = ~locked & pol_ok & kid_ok & rsv_ok & alg_ok;

  assign unused_fields = ^{wr_word.lock, wr_word.ksel, wr_word.save,
                           wr_word.byp};

endmodule

// File: rtl/enc_act_store.sv
module enc_act_store
  import enc_act_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     commit,
  input  logic     smi_evt,
  input  act_reg_t wr_word,
  output act_reg_t cur
);

  act_reg_t nxt;

  always_comb begin
    nxt = cur;
    if (commit) begin
      nxt      = wr_word;
      nxt.lock = 1'b1;
    end else if (smi_evt) begin
      nxt.lock = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

endmodule

// File: rtl/enc_act_status.sv
module enc_act_status
  import enc_act_pkg::*;
#(
  parameter int NUM_ALG = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  act_reg_t           cur,
  input  logic               commit,
  input  logic               reject,
  input  logic               req_en,
  input  logic               req_ksel,
  output logic               wr_fault,
  output logic               key_gen_req,
  output logic               key_restore_req,
  output logic               locked,
  output logic               enc_active,
  output logic               save_key,
  output logic [POL_W-1:0]   policy_sel,
  output logic [KID_W-1:0]   keyid_bits,
  output logic [NUM_ALG-1:0] alg_allow
);

  logic unused_fields;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_fault        <= 1'b0;
      key_gen_req     <= 1'b0;
      key_restore_req <= 1'b0;
    end else begin
      wr_fault        <= reject;
      key_gen_req     <= commit & req_en & ~req_ksel;
      key_restore_req <= commit & req_en & req_ksel;
    end
  end

  assign locked     = cur.lock;
  assign enc_active = cur.en & ~cur.byp;
  assign save_key   = cur.save;
  assign policy_sel = cur.pol;
  assign keyid_bits = cur.kid;
  assign alg_allow  = cur.alg[NUM_ALG-1:0];

  assign unused_fields = ^{cur.ksel, cur.rsv_lo, cur.rsv_hi,
                           cur.alg[ALG_W-1:NUM_ALG]};

endmodule

// File: rtl/enc_act_reg.sv
module enc_act_reg
  import enc_act_pkg::*;
#(
  parameter int NUM_POL = 3,
  parameter int NUM_ALG = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               smi_evt,
  input  logic [NUM_POL-1:0] cap_policy_mask,
  input  logic [NUM_ALG-1:0] cap_alg_mask,
  input  logic [KID_W-1:0]   cap_kid_max,
  output logic [REG_W-1:0]   rd_data,
  output logic               wr_fault,
  output logic               locked,
  output logic               enc_active,
  output logic               save_key,
  output logic [POL_W-1:0]   policy_sel,
  output logic [KID_W-1:0]   keyid_bits,
  output logic [NUM_ALG-1:0] alg_allow,
  output logic               key_gen_req,
  output logic               key_restore_req
);

  act_reg_t wr_word;
  act_reg_t cur;
  logic     legal;
  logic     commit;
  logic     reject;

  assign wr_word = act_reg_t'(wr_data);
  assign commit  = wr_en & legal;
  assign reject  = wr_en & ~legal;
  assign rd_data = cur;

  enc_act_validate #(.NUM_POL(NUM_POL), .NUM_ALG(NUM_ALG)) u_validate (
    .wr_word     (wr_word),
    .locked      (cur.lock),
    .cap_pol     (cap_policy_mask),
    .cap_alg     (cap_alg_mask),
    .cap_kid_max (cap_kid_max),
    .legal       (legal)
  );

  enc_act_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .smi_evt (smi_evt),
    .wr_word (wr_word),
    .cur     (cur)
  );

  enc_act_status #(.NUM_ALG(NUM_ALG)) u_status (
    .clk             (clk),
    .rst_n           (rst_n),
    .cur             (cur),
    .commit          (commit),
    .reject          (reject),
    .req_en          (wr_word.en),
    .req_ksel        (wr_word.ksel),
    .wr_fault        (wr_fault),
    .key_gen_req     (key_gen_req),
    .key_restore_req (key_restore_req),
    .locked          (locked),
    .enc_active      (enc_active),
    .save_key        (save_key),
    .policy_sel      (policy_sel),
    .keyid_bits      (keyid_bits),
    .alg_allow       (alg_allow)
  );

endmodule

// File: rtl/enc_act_chk.sv
module enc_act_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        smi_evt,
  input logic [63:0] rd_data,
  input logic        wr_fault,
  input logic        locked,
  input logic        enc_active,
  input logic        key_gen_req,
  input logic        key_restore_req
);

  // R2
  unlocked_write_resolves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !locked |=> wr_fault || locked);

  // R3
  fault_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> $past(wr_en));

  // R3
  fault_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> !key_gen_req && !key_restore_req);

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R9
  locked_write_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && locked |=> wr_fault);

  // R9
  locked_contents_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(rd_data));

  // R10
  smi_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_evt |=> locked);

  // R11
  active_matches_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_active == (rd_data[1] && !rd_data[31]));

  // R12
  single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({key_gen_req, key_restore_req}) <= 1);

  // R12
  request_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_gen_req || key_restore_req |-> locked && rd_data[1]);

endmodule

bind enc_act_reg enc_act_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .wr_en           (wr_en),
  .smi_evt         (smi_evt),
  .rd_data         (rd_data),
  .wr_fault        (wr_fault),
  .locked          (locked),
  .enc_active      (enc_active),
  .key_gen_req     (key_gen_req),
  .key_restore_req (key_restore_req)
);

// File: tb/enc_act_reg_test.sv
module enc_act_reg_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        smi_evt = 1'b0;
  logic [2:0]  cap_policy_mask = 3'b111;
  logic [2:0]  cap_alg_mask = 3'b111;
  logic [3:0]  cap_kid_max = 4'd0;
  logic [63:0] rd_data;
  logic        wr_fault, locked, enc_active, save_key;
  logic [3:0]  policy_sel, keyid_bits;
  logic [2:0]  alg_allow;
  logic        key_gen_req, key_restore_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  enc_act_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .smi_evt(smi_evt), .cap_policy_mask(cap_policy_mask),
    .cap_alg_mask(cap_alg_mask), .cap_kid_max(cap_kid_max),
    .rd_data(rd_data), .wr_fault(wr_fault), .locked(locked),
    .enc_active(enc_active), .save_key(save_key), .policy_sel(policy_sel),
    .keyid_bits(keyid_bits), .alg_allow(alg_allow),
    .key_gen_req(key_gen_req), .key_restore_req(key_restore_req)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model of the write rules.
  function automatic bit model_legal(input logic [63:0] d, input logic [2:0] pm,
                                     input logic [2:0] am, input logic [3:0] mk);
    logic [3:0]  pol = d[7:4];
    logic [3:0]  kid = d[35:32];
    logic [15:0] alg = d[63:48];
    bit ok = 1'b1;
    if (d[30:8] != '0 || d[47:36] != '0) ok = 1'b0;
    if (kid > mk) ok = 1'b0;
    if (kid != 0 && !d[1]) ok = 1'b0;
    if (pol > 4'd2) ok = 1'b0;
    else if (!pm[pol[1:0]]) ok = 1'b0;
    if (alg[15:3] != '0) ok = 1'b0;
    if ((alg[2:0] & ~am) != '0) ok = 1'b0;
    return ok;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; smi_evt = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_case(input logic [63:0] d, input logic [2:0] pm,
                          input logic [2:0] am, input logic [3:0] mk,
                          input string req);
    bit lg;
    lg = model_legal(d, pm, am, mk);
    cap_policy_mask = pm; cap_alg_mask = am; cap_kid_max = mk;
    do_reset();
    do_write(d);
    check(wr_fault == !lg, req, 64'(wr_fault), 64'(!lg));
    check(rd_data == (lg ? (d | 64'd1) : 64'd0), req, rd_data,
          lg ? (d | 64'd1) : 64'd0);
    check(locked == lg, req, 64'(locked), 64'(lg));
    check(key_gen_req == (lg && d[1] && !d[2]), {req, "/R12"},
          64'(key_gen_req), 64'(lg && d[1] && !d[2]));
    check(key_restore_req == (lg && d[1] && d[2]), {req, "/R12"},
          64'(key_restore_req), 64'(lg && d[1] && d[2]));
    check(enc_active == (lg && d[1] && !d[31]), {req, "/R11"},
          64'(enc_active), 64'(lg && d[1] && !d[31]));
    @(negedge clk);
    // R3 one-cycle pulses
    check(!wr_fault && !key_gen_req && !key_restore_req, {req, "/R3"},
          {61'd0, wr_fault, key_gen_req, key_restore_req}, 64'd0);
  endtask

  initial begin
    logic [63:0] d;
    logic [63:0] first;

    // R1 reset state
    do_reset();
    check(rd_data == 64'd0, "R1", rd_data, 64'd0);
    check(!locked && !wr_fault && !enc_active && !key_gen_req && !key_restore_req,
          "R1", {59'd0, locked, wr_fault, enc_active, key_gen_req, key_restore_req},
          64'd0);

    // R6 policy codes against capability masks
    for (int p = 0; p < 16; p++)
      for (int pm = 0; pm < 8; pm++)
        run_case(64'd2 | (64'(p) << 4), 3'(pm), 3'b111, 4'd0, "R6");

    // R4 / R5 key-ID count against limit and enable
    for (int k = 0; k < 16; k++)
      for (int mk = 0; mk < 16; mk++)
        for (int en = 0; en < 2; en++)
          run_case((64'(k) << 32) | (64'(en) << 1), 3'b001, 3'b111, 4'(mk),
                   (k > mk) ? "R4" : "R5");

    // R7 algorithm bits against capability mask
    for (int b = 48; b < 64; b++)
      for (int am = 0; am < 8; am++)
        run_case(64'd2 | (64'd1 << b), 3'b111, 3'(am), 4'd0, "R7");

    // R8 reserved bits one at a time
    for (int b = 8; b < 48; b++)
      if (b <= 30 || b >= 36)
        run_case(64'd2 | (64'd1 << b), 3'b111, 3'b111, 4'd0, "R8");

    // R2 / R11 / R12 flag combinations, bit 0 written both ways
    for (int m = 0; m < 32; m++) begin
      d = 64'(m & 1) | (64'((m >> 1) & 1) << 1) | (64'((m >> 2) & 1) << 2) |
          (64'((m >> 3) & 1) << 3) | (64'((m >> 4) & 1) << 31) |
          (64'h2 << 4) | (64'h5 << 48);
      run_case(d, 3'b100, 3'b101, 4'd0, "R2");
    end

    // R9 writes after lock
    cap_policy_mask = 3'b111; cap_alg_mask = 3'b111; cap_kid_max = 4'd8;
    do_reset();
    first = 64'h0007_0008_0000_0012;
    do_write(first);
    check(rd_data == (first | 64'd1), "R9 setup", rd_data, first | 64'd1);
    do_write(64'h0001_0000_0000_0006);
    check(wr_fault == 1'b1, "R9", 64'(wr_fault), 64'd1);
    check(rd_data == (first | 64'd1), "R9", rd_data, first | 64'd1);
    check(!key_gen_req && !key_restore_req, "R9", 64'(key_restore_req), 64'd0);
    repeat (5) @(negedge clk);
    check(locked == 1'b1 && rd_data == (first | 64'd1), "R9 hold", rd_data,
          first | 64'd1);

    // R10 event locks an empty register, later event is inert
    do_reset();
    @(negedge clk) smi_evt = 1'b1;
    @(negedge clk) smi_evt = 1'b0;
    check(rd_data == 64'd1, "R10", rd_data, 64'd1);
    do_write(64'd2);
    check(wr_fault == 1'b1, "R10", 64'(wr_fault), 64'd1);
    check(rd_data == 64'd1, "R10", rd_data, 64'd1);
    do_reset();
    do_write(first);
    @(negedge clk) smi_evt = 1'b1;
    @(negedge clk) smi_evt = 1'b0;
    check(rd_data == (first | 64'd1), "R10", rd_data, first | 64'd1);

    // R1 reset reopens
    do_reset();
    check(rd_data == 64'd0 && !locked, "R1 reopen", rd_data, 64'd0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule